// File: doc/BRIEF.md
# Byte-Wide EPROM Read Sequencer

This block sits between a synchronous host and one asynchronous, byte-wide read-only memory with a 20-bit address. The host presents a single-cycle request with an address. The block then runs a timed read cycle on the memory pins. It drives the address and pulls chip enable low. It lowers output enable late enough to meet the output-enable access time. When the address and chip-enable access time has passed, it captures the byte and returns it with a one-cycle valid strobe. It then releases both enables and holds off the next request until the memory's outputs have floated.

The three timing limits are given in nanoseconds together with the clock period. They are turned into whole clock counts, rounded up. Between reads, chip enable stays high, which keeps the memory in its low-power standby with outputs in high impedance. An identification request forces every address line except bit 0 to zero. It also raises an enable for the external high-voltage signature driver, so the memory returns its maker byte (bit 0 low) or its device byte (bit 0 high).

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, mem_ce_n and mem_oe_n are 1, rsp_valid and sig_hv_en are 0, and rsp_data is 0.
- R2: A request is taken at a rising edge only when req_valid and req_ready are both 1, and req_ready is 1 only while the block is idle. A request presented while busy has no effect on mem_addr, sig_hv_en, rsp_data or the timing of the access in progress.
- R3: In the cycle after a request is taken, mem_ce_n is 0 and mem_addr carries the request address. mem_addr does not change while mem_ce_n stays 0.
- R4: mem_oe_n is 0 for exactly OE_CYC consecutive cycles, and these end at the capture edge. mem_oe_n is never 0 while mem_ce_n is 1.
- R5: The byte on mem_q is captured at the rising edge that ends the ACC_CYC-th cycle with mem_ce_n low. In the following cycle rsp_data holds that byte and rsp_valid is 1 for that single cycle.
- R6: mem_ce_n and mem_oe_n return to 1 at the capture edge. req_ready stays 0 for the FLT_CYC cycles that follow and only then returns to 1.
- R7: Whenever no read is in progress, mem_ce_n and mem_oe_n are both 1 (standby).
- R8: With req_id = 1 the driven address is zero except bit 0, which copies req_addr[0]. sig_hv_en is 1 in exactly the cycles where mem_ce_n is 0 for that access. The byte returned is the memory's identifier: 0x20 for bit 0 = 0 and 0x42 for bit 0 = 1.
- R9: ACC_CYC = max(1, ceil(T_ACC_NS*1000/CLK_PS)). OE_CYC = min(ACC_CYC, max(1, ceil(T_OE_NS*1000/CLK_PS))). FLT_CYC = ceil(T_FLOAT_NS*1000/CLK_PS), which may be 0.
- R10: rsp_valid is 1 only in the cycle after a capture edge, and rsp_data changes only in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | High while idle; a request is taken when both are high |
| req_addr | input | 20 | Byte address of the request |
| req_id | input | 1 | Identification read instead of array read |
| rsp_data | output | 8 | Captured byte |
| rsp_valid | output | 1 | One-cycle strobe marking new rsp_data |
| mem_addr | output | 20 | Address lines to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_q | input | 8 | Data lines from the memory |
| sig_hv_en | output | 1 | Enable for the external signature-voltage driver |

## Verification
Counting from the edge that takes a request, chip enable and the address are due one cycle later. Output enable falls after the edge numbered ACC_CYC-OE_CYC. rsp_valid and the byte arrive in the cycle after edge ACC_CYC, and req_ready returns FLT_CYC cycles after that. The bench holds a behavioural model that steps on every rising edge from the inputs alone and compares every output at the falling edge. Its memory model only returns the true byte once chip enable and output enable have each been low for their full cycle counts, so a capture made too early shows up as a wrong byte.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_e;

  // whole clock cycles covering a nanosecond delay, rounded up
  function automatic int ns_to_cyc(input int t_ns, input int clk_ps);
    return (t_ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // count value (cycles of chip enable low) at which output enable starts
  function automatic int oe_lead(input int acc, input int oe);
    return acc - oe + 1;
  endfunction

endpackage

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
  import eprom_rd_pkg::*;
#(
  parameter int ACC_CYC = 12,
  parameter int OE_CYC  = 6,
  parameter int FLT_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_id,
  output logic req_ready,
  output logic accept,
  output logic sample_evt,
  output logic ce_n,
  output logic oe_n,
  output logic hv_en
);

  localparam int CNT_W    = $clog2(max2(ACC_CYC, FLT_CYC) + 1);
  localparam int OE_FIRST = oe_lead(ACC_CYC, OE_CYC);
  localparam logic [CNT_W-1:0] ACC_LIM = CNT_W'(ACC_CYC);
  localparam logic [CNT_W-1:0] OE_LIM  = CNT_W'(OE_FIRST);
  localparam logic [CNT_W-1:0] FLT_LIM = CNT_W'(FLT_CYC);
  localparam rd_state_e AFTER_CAP = (FLT_CYC == 0) ? ST_IDLE : ST_FLOAT;

  rd_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic float_done;
  logic ce_d, oe_d, hv_d;

  assign req_ready  = (st_q == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign sample_evt = (st_q == ST_ACCESS) && (cnt_q == ACC_LIM);

  generate
    if (FLT_CYC == 0) begin : g_nofloat
      assign float_done = 1'b1;
    end else begin : g_float
      assign float_done = (st_q == ST_FLOAT) && (cnt_q == FLT_LIM);
      AST_FLOAT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_n) |-> !req_ready); // R6
    end
  endgenerate

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d  = ST_ACCESS;
          cnt_d = CNT_W'(1);
        end else begin
          cnt_d = '0;
        end
      end
      ST_ACCESS: begin
        if (sample_evt) begin
          st_d  = AFTER_CAP;
          cnt_d = (AFTER_CAP == ST_FLOAT) ? CNT_W'(1) : '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_FLOAT: begin
        if (float_done) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  assign ce_d = (st_d != ST_ACCESS);
  assign oe_d = !((st_d == ST_ACCESS) && (cnt_d >= OE_LIM));
  assign hv_d = accept ? req_id : ((st_d == ST_ACCESS) && hv_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      hv_en <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ce_n  <= ce_d;
      oe_n  <= oe_d;
      hv_en <= hv_d;
    end
  end

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ce_n); // R4
  AST_SAMPLE_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> (!oe_n && !ce_n)); // R5
  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && oe_n)); // R7
  AST_CE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ce_n); // R3
  AST_HV_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en |-> !ce_n); // R8
  AST_RELEASE_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> (ce_n && oe_n)); // R6

endmodule

// File: rtl/eprom_rd_addr.sv
module eprom_rd_addr #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              ce_n,
  input  logic              hv_en,
  output logic [ADDR_W-1:0] mem_addr
);

  // identification reads keep only the byte-select bit
  function automatic logic [ADDR_W-1:0] id_form(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r    = '0;
    r[0] = a[0];
    return r;
  endfunction

  logic [ADDR_W-1:0] addr_d;
  assign addr_d = req_id ? id_form(req_addr) : req_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_addr <= '0;
    else if (accept) mem_addr <= addr_d;
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> $stable(mem_addr)); // R3
  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en |-> ((mem_addr >> 1) == '0)); // R8

endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_evt,
  input  logic [DATA_W-1:0] mem_q,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= sample_evt;
      if (sample_evt) rsp_data <= mem_q;
    end
  end

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5
  AST_DATA_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_data) |-> rsp_valid); // R10

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 10000,
  parameter int T_ACC_NS   = 120,
  parameter int T_OE_NS    = 60,
  parameter int T_FLOAT_NS = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_id,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_q,
  output logic              sig_hv_en
);

  // R9: delay counts in whole clock cycles
  localparam int ACC_CYC = max2(1, ns_to_cyc(T_ACC_NS, CLK_PS));
  localparam int OE_CYC  = min2(ACC_CYC, max2(1, ns_to_cyc(T_OE_NS, CLK_PS)));
  localparam int FLT_CYC = ns_to_cyc(T_FLOAT_NS, CLK_PS);

  logic accept;
  logic sample_evt;

  eprom_rd_seq #(
    .ACC_CYC (ACC_CYC),
    .OE_CYC  (OE_CYC),
    .FLT_CYC (FLT_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_id     (req_id),
    .req_ready  (req_ready),
    .accept     (accept),
    .sample_evt (sample_evt),
    .ce_n       (mem_ce_n),
    .oe_n       (mem_oe_n),
    .hv_en      (sig_hv_en)
  );

  eprom_rd_addr #(
    .ADDR_W (ADDR_W)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .req_id   (req_id),
    .req_addr (req_addr),
    .ce_n     (mem_ce_n),
    .hv_en    (sig_hv_en),
    .mem_addr (mem_addr)
  );

  eprom_rd_capture #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_evt (sample_evt),
    .mem_q      (mem_q),
    .rsp_data   (rsp_data),
    .rsp_valid  (rsp_valid)
  );

  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(mem_addr)); // R2

endmodule

// File: tb/eprom_rd_ctrl_bench.sv
module eprom_rd_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_PS     = CLK_PERIOD * 1000;
  localparam int ACC_NS     = 120;
  localparam int OE_NS      = 60;
  localparam int FLT_NS     = 50;

  // delay counts worked out by counting up, clamped as the requirements state
  function automatic int cycles_for(input int t_ns);
    int c;
    c = 0;
    while (c * CLK_PS < t_ns * 1000) c++;
    return c;
  endfunction

  int tacc, toe, tfl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [19:0] req_addr;
  logic        req_id;
  logic [7:0]  rsp_data;
  logic        rsp_valid;
  logic [19:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_oe_n;
  logic [7:0]  mem_q;
  logic        sig_hv_en;

  eprom_rd_ctrl #(
    .ADDR_W (20), .DATA_W (8), .CLK_PS (CLK_PS),
    .T_ACC_NS (ACC_NS), .T_OE_NS (OE_NS), .T_FLOAT_NS (FLT_NS)
  ) u_eprom_rd_ctrl (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_id (req_id), .rsp_data (rsp_data),
    .rsp_valid (rsp_valid), .mem_addr (mem_addr), .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n), .mem_q (mem_q), .sig_hv_en (sig_hv_en)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [7:0] array_byte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] expect_byte(input logic [19:0] a, input bit id);
    if (id) return a[0] ? 8'h42 : 8'h20;
    return array_byte(a);
  endfunction

  // memory model: true byte only after both enables were low long enough
  int ce_cnt = 0, oe_cnt = 0, last_ce_run = 0, last_oe_run = 0;
  always @(negedge clk) begin
    if (mem_ce_n) begin
      if (ce_cnt > 0) last_ce_run = ce_cnt;
      ce_cnt = 0;
    end else ce_cnt++;
    if (mem_oe_n) begin
      if (oe_cnt > 0) last_oe_run = oe_cnt;
      oe_cnt = 0;
    end else oe_cnt++;
    if (ce_cnt >= tacc && oe_cnt >= toe) begin
      if (sig_hv_en) mem_q = ((mem_addr >> 1) == 20'd0) ? (mem_addr[0] ? 8'h42 : 8'h20) : 8'hEE;
      else mem_q = array_byte(mem_addr);
    end else mem_q = 8'hEE;
  end

  // reference model: 0 idle, 1 access, 2 float
  int          m_kind = 0;
  int          m_k = 0;
  logic [19:0] m_addr = '0;
  bit          m_id = 0;
  bit          m_rv = 0;
  logic [7:0]  m_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_kind = 0; m_k = 0; m_rv = 0; m_rd = '0; m_id = 0;
    end else begin
      m_rv = 0;
      case (m_kind)
        0: if (req_valid) begin
          m_kind = 1; m_k = 1; m_id = req_id;
          m_addr = req_id ? {19'd0, req_addr[0]} : req_addr;
        end
        1: if (m_k == tacc) begin
          m_rv = 1; m_rd = expect_byte(m_addr, m_id);
          m_kind = (tfl > 0) ? 2 : 0; m_k = 1;
        end else m_k++;
        default: if (m_k == tfl) m_kind = 0; else m_k++;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && started) begin
      chk(m_kind == 2 ? "R6 req_ready in float" : "R2 req_ready", 32'(req_ready), 32'(m_kind == 0));
      chk(m_kind == 1 ? "R3 mem_ce_n in access" : "R7 mem_ce_n standby", 32'(mem_ce_n), 32'(m_kind != 1));
      chk("R4 mem_oe_n", 32'(mem_oe_n), 32'(!(m_kind == 1 && m_k >= tacc - toe + 1)));
      chk("R10 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      chk(m_rv ? "R5 rsp_data" : "R10 rsp_data held", 32'(rsp_data), 32'(m_rd));
      chk("R8 sig_hv_en", 32'(sig_hv_en), 32'(m_kind == 1 && m_id));
      if (m_kind == 1) chk(m_id ? "R8 id address" : "R3 mem_addr", 32'(mem_addr), 32'(m_addr));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog R2 actual=%0d expected<=100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic do_req(input logic [19:0] a, input bit id);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_id = id;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    tacc = cycles_for(ACC_NS); if (tacc < 1) tacc = 1;
    toe  = cycles_for(OE_NS);  if (toe < 1) toe = 1; if (toe > tacc) toe = tacc;
    tfl  = cycles_for(FLT_NS);
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_id = 1'b0; mem_q = 8'hEE;
    repeat (4) @(negedge clk);
    // R1: values held during reset
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 mem_ce_n", 32'(mem_ce_n), 32'd1);
    chk("R1 mem_oe_n", 32'(mem_oe_n), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 sig_hv_en", 32'(sig_hv_en), 32'd0);
    chk("R1 rsp_data", 32'(rsp_data), 32'd0);
    rst_n = 1'b1;
    started = 1;

    do_req(20'h12345, 1'b0);
    wait_idle();
    // R9: run lengths of both enables match the rounded-up counts
    chk("R9 chip enable low cycles", 32'(last_ce_run), 32'(tacc));
    chk("R9 output enable low cycles", 32'(last_oe_run), 32'(toe));

    // back-to-back array reads at the address extremes
    do_req(20'h00000, 1'b0);
    do_req(20'hFFFFF, 1'b0);
    do_req(20'h80001, 1'b0);

    // R2: request held while busy must be ignored
    do_req(20'h0ABCD, 1'b0);
    req_valid = 1'b1; req_addr = 20'h55555; req_id = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();

    // R8: identification reads, upper address bits forced to zero
    do_req(20'hFFFF0, 1'b1);
    do_req(20'h00001, 1'b1);
    do_req(20'hABCDF, 1'b1);
    wait_idle();

    for (int i = 0; i < 24; i++) begin
      do_req(20'(i * 40503 + 7), (i % 5) == 3);
      if (i % 4 == 0) repeat (i % 3) @(negedge clk);
    end
    wait_idle();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule